// File: doc/BRIEF.md
# Program Counter Jump and Table-Read Unit

This block keeps the program address of a small 8-bit controller. The address has 15 bits. It is shown as an upper byte and a lower byte, and the top bit of the upper byte always reads as zero. On each accepted operation the address moves in one of these ways: it steps forward by the instruction length, it takes a short relative jump, it takes an absolute jump that stays inside the current 4 kbyte page, or it takes a long jump that can reach any location. All address arithmetic wraps at 15 bits.

The block also runs a table-read step, so the program can fetch a constant byte from program memory and then carry on in sequence. While the table read runs, the accumulator value takes the place of the lower address byte. The byte found at that address is captured into the accumulator result. The saved lower byte is then restored and advanced by one.

Decode, the ALU and the program memory itself all sit outside this block. The memory read port has one cycle of latency.

Top module: `pcjump_unit`

## Requirements
- R1: After reset the address is 0, `illegal` is 0, `acc_out` is 0 and `busy` is 0.
- R2: The address is 15 bits wide. `pc_hi[7]` is always 0, all arithmetic wraps modulo 2^15, and `imem_addr` always equals `{pc_hi[6:0], pc_lo}`.
- R3: Operation code 0 (step) advances the address by `op_len`, which may be 0 to 3.
- R4: Operation code 1 (relative jump) adds the displacement `rel_code - 31` to the current address. The 64 codes therefore cover -31 to +32 with no gaps.
- R5: A relative jump with `rel_code` = 32 (+1) is illegal. It sets `illegal` and advances the address by 1, exactly as a one-byte no-operation would.
- R6: Each accepted operation with code 0 to 4 sets `illegal` when it is the +1 relative jump and clears it otherwise.
- R7: Operation code 2 (page jump) replaces address bits 11:0 with `jump_tgt[11:0]` and keeps bits 14:12.
- R8: Operation code 3 (long jump) loads `jump_tgt[14:0]` into the address.
- R9: Operation code 4 (table read) works as follows:
  - In the cycle after it is accepted, `imem_addr` is `{upper byte, acc_in}`.
  - One cycle later, the memory byte read from that address is loaded into `acc_out`.
  - At the same time the address becomes the original address plus 1. A carry out of the lower byte goes into the upper byte.
- R10: After a table read is accepted, `busy` stays high for exactly two cycles. Operations presented while `busy` is high are ignored.
- R11: Operation codes 5 to 7 change nothing, and neither does a cycle with `op_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 step, 1 relative, 2 page jump, 3 long jump, 4 table read |
| op_len | input | 2 | Step length in bytes |
| rel_code | input | 6 | Biased relative displacement |
| jump_tgt | input | 15 | Absolute target |
| acc_in | input | 8 | Accumulator value |
| imem_rdata | input | 8 | Program memory data, one cycle after address |
| imem_addr | output | 15 | Program memory address |
| pc_hi | output | 8 | Upper address byte, bit 7 zero |
| pc_lo | output | 8 | Lower address byte |
| acc_out | output | 8 | Accumulator loaded by table read |
| busy | output | 1 | Table read in progress |
| illegal | output | 1 | Last accepted operation was the +1 relative jump |

## Verification
The assertions assume two things about the block's surroundings:
- `imem_rdata` returns the byte for the address presented one cycle earlier.
- Reset is held long enough to cover the three-cycle history that the lower-byte restore check looks back over.

The bench meets both conditions. Its memory model is a registered function of `imem_addr`, and it releases reset only after several clocks. Some stimulus deliberately holds `op_valid` high with a long jump while a table read runs. In those cases the ignored-operation behaviour is observed at the address outputs.

// File: rtl/pcjump_pkg.sv
package pcjump_pkg;

   typedef enum logic [2:0] {
      PCJ_STEP  = 3'd0,
      PCJ_REL   = 3'd1,
      PCJ_PAGE  = 3'd2,
      PCJ_LONG  = 3'd3,
      PCJ_TABLE = 3'd4
   } pcj_op_e;

   typedef enum logic [1:0] {
      TB_IDLE = 2'd0,
      TB_ADDR = 2'd1,
      TB_DATA = 2'd2
   } pcj_tbl_e;

endpackage

// File: rtl/pcjump_rel_decode.sv
module pcjump_rel_decode #(
   parameter int REL_W  = 6,
   parameter int ADDR_W = 15
) (
   input  logic [REL_W-1:0]  code,
   output logic [ADDR_W-1:0] disp,
   output logic              forbidden
);
   localparam int BIAS = (1 << (REL_W - 1)) - 1;

   if (REL_W >= ADDR_W) begin : g_bad_width
      $error("pcjump_rel_decode: REL_W must be narrower than ADDR_W");
   end

   // biased code: 0 maps to -BIAS, all ones maps to +BIAS+1
   assign disp      = ADDR_W'(code) - ADDR_W'(BIAS);
   assign forbidden = (code == REL_W'(BIAS + 1));

endmodule

// File: rtl/pcjump_next_addr.sv
module pcjump_next_addr
   import pcjump_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 12,
   parameter int LEN_W  = 2
) (
   input  logic [ADDR_W-1:0] cur,
   input  pcj_op_e           op,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W-1:0] disp,
   input  logic              forbidden,
   input  logic [ADDR_W-1:0] tgt,
   output logic [ADDR_W-1:0] nxt
);
   logic [ADDR_W-1:0] page_tgt;

   if (PAGE_W > ADDR_W || PAGE_W < 1) begin : g_bad_page
      $error("pcjump_next_addr: PAGE_W out of range");
   end

   if (PAGE_W < ADDR_W) begin : g_paged
      assign page_tgt = {cur[ADDR_W-1:PAGE_W], tgt[PAGE_W-1:0]};
   end else begin : g_flat
      assign page_tgt = tgt;
   end

   always_comb begin
      case (op)
         PCJ_STEP: nxt = cur + ADDR_W'(len);
         PCJ_REL:  nxt = forbidden ? cur + ADDR_W'(1) : cur + disp;
         PCJ_PAGE: nxt = page_tgt;
         PCJ_LONG: nxt = tgt;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/pcjump_tbl_seq.sv
module pcjump_tbl_seq
   import pcjump_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] lo_in,
   output logic              busy,
   output logic              done,
   output logic [BYTE_W-1:0] saved_lo
);
   pcj_tbl_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= TB_IDLE;
         saved_lo <= '0;
      end else begin
         case (state_q)
            TB_IDLE: if (start) begin
               state_q  <= TB_ADDR;
               saved_lo <= lo_in;
            end
            TB_ADDR: state_q <= TB_DATA;
            default: state_q <= TB_IDLE;
         endcase
      end
   end

   assign busy = (state_q != TB_IDLE);
   assign done = (state_q == TB_DATA);

endmodule

// File: rtl/pcjump_unit.sv
module pcjump_unit
   import pcjump_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int BYTE_W = 8,
   parameter int REL_W  = 6,
   parameter int PAGE_W = 12,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [LEN_W-1:0]  op_len,
   input  logic [REL_W-1:0]  rel_code,
   input  logic [ADDR_W-1:0] jump_tgt,
   input  logic [BYTE_W-1:0] acc_in,
   input  logic [BYTE_W-1:0] imem_rdata,
   output logic [ADDR_W-1:0] imem_addr,
   output logic [BYTE_W-1:0] pc_hi,
   output logic [BYTE_W-1:0] pc_lo,
   output logic [BYTE_W-1:0] acc_out,
   output logic              busy,
   output logic              illegal
);
   localparam int HI_W  = ADDR_W - BYTE_W;
   localparam int PAD_W = 2 * BYTE_W - ADDR_W;

   if (ADDR_W <= BYTE_W || ADDR_W >= 2 * BYTE_W) begin : g_bad_addr
      $error("pcjump_unit: ADDR_W must lie strictly between BYTE_W and 2*BYTE_W");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] nxt_pc;
   logic [ADDR_W-1:0] disp;
   logic [ADDR_W-1:0] restored;
   logic [BYTE_W-1:0] saved_lo;
   logic              forbidden;
   logic              accept;
   logic              tbl_start;
   logic              tbl_done;
   logic              known_op;
   pcj_op_e           op_e;

   assign op_e      = pcj_op_e'(op_code);
   assign accept    = op_valid && !busy;
   assign tbl_start = accept && (op_e == PCJ_TABLE);
   assign known_op  = (op_code <= 3'(PCJ_TABLE));

   pcjump_rel_decode #(.REL_W(REL_W), .ADDR_W(ADDR_W)) u_rel (
      .code      (rel_code),
      .disp      (disp),
      .forbidden (forbidden)
   );

   pcjump_next_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_next (
      .cur       (pc_q),
      .op        (op_e),
      .len       (op_len),
      .disp      (disp),
      .forbidden (forbidden),
      .tgt       (jump_tgt),
      .nxt       (nxt_pc)
   );

   pcjump_tbl_seq #(.BYTE_W(BYTE_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tbl_start),
      .lo_in    (pc_q[BYTE_W-1:0]),
      .busy     (busy),
      .done     (tbl_done),
      .saved_lo (saved_lo)
   );

   assign restored = {pc_q[ADDR_W-1:BYTE_W], saved_lo} + ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= '0;
         acc_out <= '0;
         illegal <= 1'b0;
      end else if (tbl_done) begin
         pc_q    <= restored;
         acc_out <= imem_rdata;
      end else if (accept && known_op) begin
         illegal <= (op_e == PCJ_REL) && forbidden;
         if (op_e == PCJ_TABLE) pc_q[BYTE_W-1:0] <= acc_in;
         else                   pc_q             <= nxt_pc;
      end
   end

   assign imem_addr = pc_q;
   assign pc_lo     = pc_q[BYTE_W-1:0];

   if (PAD_W > 0) begin : g_pad_hi
      assign pc_hi = {{PAD_W{1'b0}}, pc_q[ADDR_W-1:BYTE_W]};
   end else begin : g_full_hi
      assign pc_hi = pc_q[BYTE_W-1+HI_W-HI_W:0];
   end

endmodule

// File: rtl/pcjump_checker.sv
module pcjump_checker #(
   parameter int ADDR_W = 15,
   parameter int BYTE_W = 8,
   parameter int REL_W  = 6,
   parameter int PAGE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_code,
   input logic [REL_W-1:0]  rel_code,
   input logic [BYTE_W-1:0] acc_in,
   input logic [ADDR_W-1:0] imem_addr,
   input logic [BYTE_W-1:0] pc_hi,
   input logic [BYTE_W-1:0] pc_lo,
   input logic              busy,
   input logic              illegal
);
   localparam int PLUS_ONE = 1 << (REL_W - 1);

   logic [2*BYTE_W-1:0] pcw;
   logic                take;

   assign pcw  = {pc_hi, pc_lo};
   assign take = op_valid && !busy;

   // R2: unused top bits read as zero; memory address follows the byte pair
   a_r2_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      pcw[2*BYTE_W-1:ADDR_W] == '0 && imem_addr == pcw[ADDR_W-1:0]);

   // R5: +1 relative jump flags and advances by one
   a_r5_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
      take && op_code == 3'd1 && rel_code == REL_W'(PLUS_ONE)
      |=> illegal && pcw[ADDR_W-1:0] == ADDR_W'($past(pcw) + 1'b1));

   // R7: page jump keeps bits above the page
   a_r7_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
      take && op_code == 3'd2
      |=> pcw[ADDR_W-1:PAGE_W] == $past(pcw[ADDR_W-1:PAGE_W]));

   // R9: table address uses accumulator as the low byte
   a_r9_tbl_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> imem_addr[BYTE_W-1:0] == $past(acc_in)
                      && imem_addr[ADDR_W-1:BYTE_W] == $past(pcw[ADDR_W-1:BYTE_W]));

   // R9: low byte restored and advanced at the end of a table read
   a_r9_lo_restored: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> pcw[ADDR_W-1:0] == ADDR_W'($past(pcw, 3) + 1'b1));

   // R10: busy lasts exactly two cycles
   a_r10_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);
   a_r10_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |=> !busy);

   // R10: ignored operations leave the upper byte alone mid table read
   a_r10_hold_hi: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> $stable(pc_hi));

endmodule

bind pcjump_unit pcjump_checker #(
   .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .REL_W(REL_W), .PAGE_W(PAGE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .rel_code  (rel_code),
   .acc_in    (acc_in),
   .imem_addr (imem_addr),
   .pc_hi     (pc_hi),
   .pc_lo     (pc_lo),
   .busy      (busy),
   .illegal   (illegal)
);

// File: tb/pcjump_unit_tb.sv
`timescale 1ns/1ps
module pcjump_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [1:0]  op_len = '0;
   logic [5:0]  rel_code = '0;
   logic [14:0] jump_tgt = '0;
   logic [7:0]  acc_in = '0;
   logic [7:0]  imem_rdata = '0;
   logic [14:0] imem_addr;
   logic [7:0]  pc_hi, pc_lo, acc_out;
   logic        busy, illegal;

   int    nchecks = 0;
   int    nerr = 0;
   bit    finished = 1'b0;
   string cur_tag = "R1";

   // reference model state
   int m_pc = 0, m_acc = 0, m_ill = 0, m_busy = 0, m_save = 0, m_addr = 0;

   always #2.5 clk = ~clk;

   pcjump_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_len(op_len), .rel_code(rel_code), .jump_tgt(jump_tgt), .acc_in(acc_in),
      .imem_rdata(imem_rdata), .imem_addr(imem_addr), .pc_hi(pc_hi), .pc_lo(pc_lo),
      .acc_out(acc_out), .busy(busy), .illegal(illegal)
   );

   function automatic int memf(input int a);
      if (a == 'h041F) return 'h25;
      return ((a * 53) ^ (a >> 5)) & 255;
   endfunction

   always @(posedge clk) imem_rdata <= 8'(memf(int'(imem_addr)));

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_acc = 0; m_ill = 0; m_busy = 0; m_save = 0;
      end else if (m_busy == 1) begin
         m_busy = 2;
      end else if (m_busy == 2) begin
         m_acc  = memf(m_addr);
         m_pc   = ((m_pc & 'h7F00) + m_save + 1) & 'h7FFF;
         m_busy = 0;
      end else if (op_valid && op_code <= 4) begin
         m_ill = (op_code == 1 && rel_code == 32) ? 1 : 0;
         case (op_code)
            0: m_pc = (m_pc + op_len) & 'h7FFF;
            1: m_pc = (rel_code == 32) ? (m_pc + 1) & 'h7FFF
                                       : (m_pc + int'(rel_code) - 31) & 'h7FFF;
            2: m_pc = (m_pc & 'h7000) | (jump_tgt & 'h0FFF);
            3: m_pc = jump_tgt;
            default: begin
               m_save = m_pc & 'hFF;
               m_pc   = (m_pc & 'h7F00) | acc_in;
               m_addr = m_pc;
               m_busy = 1;
            end
         endcase
      end
   end

   task automatic chk(input string tag, input int act, input int exp, input string what);
      nchecks++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2", int'(pc_hi[7]), 0, "pc_hi bit 7");
         chk(cur_tag, int'({pc_hi[6:0], pc_lo}), m_pc, "address");
         chk("R2", int'(imem_addr), m_pc, "imem_addr");
         chk(cur_tag, int'(illegal), m_ill, "illegal");
         chk("R10", int'(busy), (m_busy != 0) ? 1 : 0, "busy");
         chk(cur_tag, int'(acc_out), m_acc, "acc_out");
      end
   end

   task automatic issue(input int op, input int len, input int rc, input int tg,
                        input int acc, input string tag);
      cur_tag  = tag;
      op_valid = 1'b1;
      op_code  = 3'(op);
      op_len   = 2'(len);
      rel_code = 6'(rc);
      jump_tgt = 15'(tg);
      acc_in   = 8'(acc);
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   function automatic int pcv();
      return int'({pc_hi[6:0], pc_lo});
   endfunction

   initial begin
      #(200000 * 5);
      if (!finished) begin
         nchecks++; nerr++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", pcv(), 0, "reset address");
      chk("R1", int'(illegal), 0, "reset illegal");
      chk("R1", int'(acc_out), 0, "reset acc");
      chk("R1", int'(busy), 0, "reset busy");

      // R4 worked case: 0205 + 0A
      issue(3, 0, 0, 'h0205, 0, "R8");
      chk("R8", pcv(), 'h0205, "long jump");
      issue(1, 0, 41, 0, 0, "R4");
      chk("R4", pcv(), 'h020F, "relative +0A");

      // R4 / R5 sweep every code
      for (int c = 0; c < 64; c++) begin
         issue(3, 0, 0, 'h2100, 0, "R8");
         issue(1, 0, c, 0, 0, (c == 32) ? "R5" : "R4");
         chk((c == 32) ? "R5" : "R4", pcv(),
             (c == 32) ? 'h2101 : ('h2100 + c - 31), "relative sweep");
         chk("R5", int'(illegal), (c == 32) ? 1 : 0, "illegal flag");
      end

      // R4 wrap below zero
      issue(3, 0, 0, 'h0005, 0, "R8");
      issue(1, 0, 0, 0, 0, "R4");
      chk("R4", pcv(), 'h7FE6, "relative wrap");

      // R3 steps and wrap
      issue(3, 0, 0, 'h7FFE, 0, "R8");
      issue(0, 3, 0, 0, 0, "R3");
      chk("R3", pcv(), 'h0001, "step wrap");
      issue(0, 0, 0, 0, 0, "R3");
      chk("R3", pcv(), 'h0001, "step zero");
      issue(0, 2, 0, 0, 0, "R3");
      chk("R3", pcv(), 'h0003, "step two");

      // R7 page jump
      issue(3, 0, 0, 'h5ABC, 0, "R8");
      issue(2, 0, 0, 'h7123, 0, "R7");
      chk("R7", pcv(), 'h5123, "page jump");

      // R5 / R11 / R6: flag holds across reserved codes, cleared by a step
      issue(1, 0, 32, 0, 0, "R5");
      chk("R5", int'(illegal), 1, "flag set");
      issue(5, 1, 0, 'h1111, 0, "R11");
      issue(7, 1, 0, 'h1111, 0, "R11");
      chk("R11", pcv(), 'h5124, "reserved no change");
      chk("R11", int'(illegal), 1, "reserved keeps flag");
      issue(0, 1, 0, 0, 0, "R6");
      chk("R6", int'(illegal), 0, "flag cleared");

      // R9 worked table read
      issue(3, 0, 0, 'h0435, 0, "R8");
      issue(4, 0, 0, 0, 'h1F, "R9");
      chk("R9", int'(imem_addr), 'h041F, "table address");
      chk("R10", int'(busy), 1, "busy first");
      @(negedge clk);
      chk("R10", int'(busy), 1, "busy second");
      @(negedge clk);
      chk("R10", int'(busy), 0, "busy done");
      chk("R9", int'(acc_out), 'h25, "table data");
      chk("R9", pcv(), 'h0436, "low byte restored");

      // R9 carry into upper byte
      issue(3, 0, 0, 'h12FF, 0, "R8");
      issue(4, 0, 0, 0, 'h80, "R9");
      repeat (2) @(negedge clk);
      chk("R9", pcv(), 'h1300, "restore carry");
      chk("R9", int'(acc_out), memf('h1280), "table data 2");

      // R10 operations ignored while busy
      issue(4, 0, 0, 0, 'h07, "R10");
      cur_tag = "R10";
      op_valid = 1'b1; op_code = 3'd3; jump_tgt = 15'h3333;
      repeat (2) @(negedge clk);
      op_valid = 1'b0;
      chk("R10", pcv(), 'h1301, "busy ignores jump");
      chk("R10", int'(acc_out), memf('h1307), "busy table data");

      // R11 idle cycles
      cur_tag = "R11";
      repeat (3) @(negedge clk);
      chk("R11", pcv(), 'h1301, "idle hold");

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
      $finish;
   end
endmodule